// File: doc/BRIEF.md
# Sleep-mode and reset sequencer

This block decides when the core of a small 8-bit controller sleeps, wakes and is held in reset. Software requests a light sleep or a deep sleep by writing two mode bits. The request takes effect at the next machine-cycle boundary after the write. In light sleep the CPU clock is gated off, while the peripheral clock and the oscillator keep running. Any enabled interrupt line wakes the core. In deep sleep the CPU clock, the peripheral clock and the oscillator are all off, and only the external reset pin can bring the core back. While the core sleeps, the block also tells the pad logic which fixed levels to force on the address-latch strobe, the program-read strobe and the port pads.

The block is a five-state machine:
- RESET holds the internal reset with the clocks running.
- RUN is normal operation.
- IDLE is light sleep.
- PDOWN is deep sleep.
- WARM holds reset while a restarted oscillator settles.

The transitions are:
- RESET→RUN when the pin is low.
- RUN→RESET on a qualified pin reset.
- RUN→PDOWN or RUN→IDLE on a machine-cycle strobe with a pending request.
- IDLE→RESET on a qualified pin reset.
- IDLE→RUN on any interrupt.
- PDOWN→WARM when the pin goes high.
- WARM→RESET when the settle count has elapsed.

Register and RAM contents are only held. Nothing here clears them.

Top module: `pwr_rst_ctl`

## Requirements
- R1: During power-on reset (por_n low) and in RESET, int_rst=1 and cpu_clk_en, per_clk_en and osc_en are 1. The block stays in RESET for as long as rst_pin is high.
- R2: A write with pcon_wr captures pcon_mode. Bit 0 requests light sleep and bit 1 requests deep sleep. When both bits are set, deep sleep wins, and a value of 0 requests nothing. Entry happens on the first mc_strobe in a cycle after the write cycle, never earlier.
- R3: In light sleep, cpu_clk_en=0, per_clk_en=1, osc_en=1 and int_rst=0.
- R4: In light sleep, any bit of irq_req high returns the block to RUN at the next clock edge, with cpu_clk_en=1.
- R5: In deep sleep, cpu_clk_en, per_clk_en, osc_en and int_rst are all 0, and irq_req has no effect.
- R6: A high rst_pin in deep sleep moves the block to WARM at the next edge: osc_en=1, int_rst=1 and both clock enables 0. WARM lasts max(settle_cycles,1) clock cycles whatever rst_pin does, and then the block enters RESET.
- R7: In RUN or light sleep, a reset is issued only after rst_pin has been high across two consecutive mc_strobe pulses. A low pin in between restarts the count. A qualified reset takes priority over mode entry and over wake-up.
- R8: RESET moves to RUN at the first clock edge where rst_pin is low, and int_rst then drops to 0.
- R9: pad_hold=1 in light sleep, deep sleep and WARM, and 0 otherwise. ale_hold_val and psen_hold_val are 1 in light sleep and 0 in deep sleep and WARM.
- R10: p0_hiz=1 while pad_hold=1 and ext_code=1. p2_addr_sel=1 only in light sleep with ext_code=1. Otherwise the ports show latch data (both signals 0).
- R11: Entering RESET discards a pending mode request, so a later mc_strobe leaves the block in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| por_n | input | 1 | Asynchronous power-on reset of this block, active low |
| rst_pin | input | 1 | External reset pin, active high |
| mc_strobe | input | 1 | One-clock pulse at each machine-cycle boundary |
| pcon_wr | input | 1 | Write strobe of the power-control mode bits |
| pcon_mode | input | 2 | Bit 0 requests light sleep, bit 1 requests deep sleep |
| irq_req | input | NIRQ | Enabled interrupt request lines |
| ext_code | input | 1 | 1 when code is fetched from external program memory |
| settle_cycles | input | CNT_W | Oscillator settle time in clock cycles |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| int_rst | output | 1 | Internal reset, active high |
| pad_hold | output | 1 | Forced pad levels active |
| ale_hold_val | output | 1 | Level forced on the address-latch strobe |
| psen_hold_val | output | 1 | Level forced on the program-read strobe |
| p0_hiz | output | 1 | Float port 0 |
| p2_addr_sel | output | 1 | Port 2 shows the address instead of latch data |

## Verification
The bench writes a mode request in the same cycle as a strobe. A design that latched the request combinationally would fall asleep one machine cycle early. It writes both mode bits together, which catches a design where light sleep wins over deep sleep.

It drops the reset pin in the middle of WARM. A sequencer that left WARM early would release reset before the oscillator settled. It uses a settle count of zero, which would hang a design with a down-counter that wraps.

It raises the pin for one strobe, drops it, and raises it again. A design that did not restart the count would reset on a glitch. It starts a reset count before writing a request, and then checks that a later strobe keeps the core awake. A design that kept stale requests across reset would sleep right after reset.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_RUN,
        ST_IDLE,
        ST_PDOWN,
        ST_WARM
    } pm_state_t;

    localparam int MODE_W   = 2;
    localparam int BIT_IDLE = 0;
    localparam int BIT_PD   = 1;

endpackage

// File: rtl/pm_mode_req.sv
module pm_mode_req
    import pwr_rst_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr,
    input  logic [MODE_W-1:0] wdata,
    input  logic              clear,
    output logic              want_idle,
    output logic              want_pd
);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            want_idle <= 1'b0;
            want_pd   <= 1'b0;
        end else if (clear) begin
            want_idle <= 1'b0;
            want_pd   <= 1'b0;
        end else if (wr) begin
            want_pd   <= wdata[BIT_PD];
            want_idle <= wdata[BIT_IDLE] & ~wdata[BIT_PD];
        end
    end

    // R2
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(want_idle && want_pd));

endmodule

// File: rtl/pm_rst_qual.sv
module pm_rst_qual #(
    parameter int RST_MC = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic arm,
    input  logic pin,
    input  logic strobe,
    output logic hit
);

    localparam int QW = $clog2(RST_MC + 1);
    localparam logic [QW-1:0] LAST = QW'(RST_MC - 1);

    logic [QW-1:0] cnt;

    assign hit = arm && pin && strobe && (cnt == LAST);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!arm || !pin || hit) begin
            cnt <= '0;
        end else if (strobe) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    qual_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!pin) |=> (cnt == '0));

endmodule

// File: rtl/pm_settle.sv
module pm_settle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    assign done = run && (({1'b0, cnt} + 1'b1) >= {1'b0, limit});

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    settle_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/pm_pad_ctl.sv
module pm_pad_ctl
    import pwr_rst_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  pm_state_t state,
    input  logic      ext_code,
    output logic      pad_hold,
    output logic      ale_hold_val,
    output logic      psen_hold_val,
    output logic      p0_hiz,
    output logic      p2_addr_sel
);

    always_comb begin
        pad_hold      = 1'b0;
        ale_hold_val  = 1'b0;
        psen_hold_val = 1'b0;
        p0_hiz        = 1'b0;
        p2_addr_sel   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                pad_hold      = 1'b1;
                ale_hold_val  = 1'b1;
                psen_hold_val = 1'b1;
                p0_hiz        = ext_code;
                p2_addr_sel   = ext_code;
            end
            ST_PDOWN, ST_WARM: begin
                pad_hold = 1'b1;
                p0_hiz   = ext_code;
            end
            default: ;
        endcase
    end

    // R10
    p0_float_chk: assert property (@(posedge clk) disable iff (!por_n)
        (p0_hiz || p2_addr_sel) |-> (pad_hold && ext_code));

    // R9
    strobe_level_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!pad_hold) |-> (!ale_hold_val && !psen_hold_val));

endmodule

// File: rtl/pwr_rst_ctl.sv
module pwr_rst_ctl
    import pwr_rst_pkg::*;
#(
    parameter int NIRQ   = 6,
    parameter int CNT_W  = 16,
    parameter int RST_MC = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin,
    input  logic              mc_strobe,
    input  logic              pcon_wr,
    input  logic [MODE_W-1:0] pcon_mode,
    input  logic [NIRQ-1:0]   irq_req,
    input  logic              ext_code,
    input  logic [CNT_W-1:0]  settle_cycles,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_en,
    output logic              int_rst,
    output logic              pad_hold,
    output logic              ale_hold_val,
    output logic              psen_hold_val,
    output logic              p0_hiz,
    output logic              p2_addr_sel
);

    pm_state_t state, state_nx;
    logic      want_idle, want_pd;
    logic      rst_hit, settle_done;
    logic      req_clear, enter_sleep;

    assign enter_sleep = (state == ST_RUN) && mc_strobe && !rst_hit && (want_idle || want_pd);
    assign req_clear   = (state == ST_RESET) || enter_sleep;

    pm_mode_req u_req (
        .clk       (clk),
        .por_n     (por_n),
        .wr        (pcon_wr),
        .wdata     (pcon_mode),
        .clear     (req_clear),
        .want_idle (want_idle),
        .want_pd   (want_pd)
    );

    pm_rst_qual #(.RST_MC(RST_MC)) u_qual (
        .clk    (clk),
        .por_n  (por_n),
        .arm    ((state == ST_RUN) || (state == ST_IDLE)),
        .pin    (rst_pin),
        .strobe (mc_strobe),
        .hit    (rst_hit)
    );

    pm_settle #(.CNT_W(CNT_W)) u_settle (
        .clk   (clk),
        .por_n (por_n),
        .run   (state == ST_WARM),
        .limit (settle_cycles),
        .done  (settle_done)
    );

    pm_pad_ctl u_pad (
        .clk           (clk),
        .por_n         (por_n),
        .state         (state),
        .ext_code      (ext_code),
        .pad_hold      (pad_hold),
        .ale_hold_val  (ale_hold_val),
        .psen_hold_val (psen_hold_val),
        .p0_hiz        (p0_hiz),
        .p2_addr_sel   (p2_addr_sel)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET: if (!rst_pin) state_nx = ST_RUN;
            ST_RUN: begin
                if (rst_hit)                  state_nx = ST_RESET;
                else if (mc_strobe && want_pd)   state_nx = ST_PDOWN;
                else if (mc_strobe && want_idle) state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (rst_hit)        state_nx = ST_RESET;
                else if (|irq_req)  state_nx = ST_RUN;
            end
            ST_PDOWN: if (rst_pin)     state_nx = ST_WARM;
            ST_WARM:  if (settle_done) state_nx = ST_RESET;
            default:  state_nx = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= state_nx;
    end

    always_comb begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        osc_en     = 1'b1;
        int_rst    = 1'b0;
        unique case (state)
            ST_RESET: int_rst = 1'b1;
            ST_RUN:   ;
            ST_IDLE:  cpu_clk_en = 1'b0;
            ST_PDOWN: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = 1'b0;
            end
            ST_WARM: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                int_rst    = 1'b1;
            end
            default: int_rst = 1'b1;
        endcase
    end

    // R4
    idle_wake_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_IDLE && |irq_req && !rst_hit) |=> cpu_clk_en && !int_rst);

    // R5
    pd_stay_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_PDOWN && !rst_pin) |=> !osc_en);

    // R6
    pd_exit_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_PDOWN && rst_pin) |=> (osc_en && int_rst && !cpu_clk_en));

    // R2
    boundary_only_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && !mc_strobe) |=> cpu_clk_en);

    // R8
    rst_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RESET && !rst_pin) |=> !int_rst);

endmodule

// File: tb/pwr_rst_ctl_bench.sv
`timescale 1ns/1ps
module pwr_rst_ctl_bench;

    localparam int NIRQ  = 6;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             por_n = 1'b0;
    logic             rst_pin = 1'b0;
    logic             mc_strobe = 1'b0;
    logic             pcon_wr = 1'b0;
    logic [1:0]       pcon_mode = 2'b00;
    logic [NIRQ-1:0]  irq_req = '0;
    logic             ext_code = 1'b0;
    logic [CNT_W-1:0] settle_cycles = 16'd5;
    logic cpu_clk_en, per_clk_en, osc_en, int_rst;
    logic pad_hold, ale_hold_val, psen_hold_val, p0_hiz, p2_addr_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_rst_ctl #(.NIRQ(NIRQ), .CNT_W(CNT_W), .RST_MC(2)) u_pwr_rst_ctl (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .mc_strobe(mc_strobe),
        .pcon_wr(pcon_wr), .pcon_mode(pcon_mode), .irq_req(irq_req),
        .ext_code(ext_code), .settle_cycles(settle_cycles),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .int_rst(int_rst), .pad_hold(pad_hold), .ale_hold_val(ale_hold_val),
        .psen_hold_val(psen_hold_val), .p0_hiz(p0_hiz), .p2_addr_sel(p2_addr_sel)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic chk_clk(input string req, input logic c, input logic p, input logic o, input logic r);
        chk(req, "cpu_clk_en", cpu_clk_en, c);
        chk(req, "per_clk_en", per_clk_en, p);
        chk(req, "osc_en", osc_en, o);
        chk(req, "int_rst", int_rst, r);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic mc_pulse();
        mc_strobe = 1'b1;
        step();
        mc_strobe = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] m);
        pcon_wr = 1'b1;
        pcon_mode = m;
        step();
        pcon_wr = 1'b0;
        pcon_mode = 2'b00;
    endtask

    task automatic wake_irq();
        irq_req = 6'b000100;
        step();
        irq_req = '0;
    endtask

    task automatic t_power_on();
        rst_pin = 1'b1;
        step(); step();
        chk_clk("R1", 1, 1, 1, 1);
        por_n = 1'b1;
        step(); step(); step();
        chk("R1", "int_rst held by pin", int_rst, 1'b1);
        rst_pin = 1'b0;
        step();
        chk_clk("R8", 1, 1, 1, 0);
        chk("R9", "pad_hold in run", pad_hold, 1'b0);
    endtask

    task automatic t_idle_int();
        ext_code = 1'b0;
        write_mode(2'b01);
        step(); step();
        chk("R2", "no entry before strobe", cpu_clk_en, 1'b1);
        mc_pulse();
        chk_clk("R3", 0, 1, 1, 0);
        chk("R9", "pad_hold idle", pad_hold, 1'b1);
        chk("R9", "ale idle", ale_hold_val, 1'b1);
        chk("R9", "psen idle", psen_hold_val, 1'b1);
        chk("R10", "p0 internal idle", p0_hiz, 1'b0);
        chk("R10", "p2 internal idle", p2_addr_sel, 1'b0);
        step(); step();
        chk("R4", "stays asleep without irq", cpu_clk_en, 1'b0);
        wake_irq();
        chk("R4", "wake on irq", cpu_clk_en, 1'b1);
        chk("R9", "pad release", pad_hold, 1'b0);
    endtask

    task automatic t_idle_ext();
        ext_code = 1'b1;
        write_mode(2'b01);
        mc_pulse();
        chk("R10", "p0 float idle ext", p0_hiz, 1'b1);
        chk("R10", "p2 addr idle ext", p2_addr_sel, 1'b1);
        wake_irq();
        chk("R10", "p0 released", p0_hiz, 1'b0);
    endtask

    task automatic t_same_cycle();
        pcon_wr = 1'b1; pcon_mode = 2'b01; mc_strobe = 1'b1;
        step();
        pcon_wr = 1'b0; pcon_mode = 2'b00; mc_strobe = 1'b0;
        chk("R2", "same-cycle strobe not entry", cpu_clk_en, 1'b1);
        mc_pulse();
        chk("R2", "entry at next strobe", cpu_clk_en, 1'b0);
        wake_irq();
        write_mode(2'b00);
        mc_pulse();
        chk("R2", "zero request stays run", cpu_clk_en, 1'b1);
    endtask

    task automatic t_pdown();
        ext_code = 1'b1;
        settle_cycles = 16'd5;
        write_mode(2'b11);
        mc_pulse();
        chk_clk("R5", 0, 0, 0, 0);
        chk("R9", "ale pd", ale_hold_val, 1'b0);
        chk("R9", "psen pd", psen_hold_val, 1'b0);
        chk("R9", "pad_hold pd", pad_hold, 1'b1);
        chk("R10", "p0 float pd ext", p0_hiz, 1'b1);
        chk("R10", "p2 latch pd ext", p2_addr_sel, 1'b0);
        irq_req = 6'b111111;
        step(); step(); step();
        irq_req = '0;
        chk("R5", "irq ignored", osc_en, 1'b0);
        rst_pin = 1'b1;
        step();
        chk_clk("R6", 0, 0, 1, 1);
        step();
        rst_pin = 1'b0;
        step(); step(); step();
        chk("R6", "still warming at 4", cpu_clk_en, 1'b0);
        chk("R6", "reset held in warm", int_rst, 1'b1);
        step();
        chk_clk("R6", 1, 1, 1, 1);
        step();
        chk("R8", "release after warm", int_rst, 1'b0);
    endtask

    task automatic t_qual();
        rst_pin = 1'b1;
        mc_pulse();
        chk("R7", "one strobe no reset", int_rst, 1'b0);
        rst_pin = 1'b0;
        step();
        rst_pin = 1'b1;
        mc_pulse();
        chk("R7", "glitch restarts count", int_rst, 1'b0);
        mc_pulse();
        chk("R7", "two strobes reset", int_rst, 1'b1);
        rst_pin = 1'b0;
        step();
        chk("R8", "release", int_rst, 1'b0);
    endtask

    task automatic t_idle_reset();
        write_mode(2'b01);
        mc_pulse();
        rst_pin = 1'b1;
        mc_pulse();
        chk("R7", "idle one strobe", cpu_clk_en, 1'b0);
        mc_pulse();
        chk_clk("R7", 1, 1, 1, 1);
        rst_pin = 1'b0;
        step();
    endtask

    task automatic t_discard();
        rst_pin = 1'b1;
        mc_pulse();
        write_mode(2'b01);
        mc_pulse();
        chk_clk("R7", 1, 1, 1, 1);
        rst_pin = 1'b0;
        step();
        mc_pulse();
        chk("R11", "request discarded", cpu_clk_en, 1'b1);
    endtask

    task automatic t_settle_zero();
        settle_cycles = '0;
        write_mode(2'b10);
        mc_pulse();
        chk("R5", "pd entered", osc_en, 1'b0);
        rst_pin = 1'b1;
        step();
        chk("R6", "warm cpu off", cpu_clk_en, 1'b0);
        step();
        chk("R6", "zero settle one cycle", cpu_clk_en, 1'b1);
        rst_pin = 1'b0;
        step();
        chk("R8", "release", int_rst, 1'b0);
    endtask

    initial begin
        t_power_on();
        t_idle_int();
        t_idle_ext();
        t_same_cycle();
        t_pdown();
        t_qual();
        t_idle_reset();
        t_discard();
        t_settle_zero();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule